// File: doc/BRIEF.md
# Burst Tag/ECC Sideband Cache Reader

This block sits on the read side of a direct-mapped cache whose storage is an external memory with an 80-bit beat: 64 data bits plus a 16-bit sideband lane. A cache block of 64 bytes arrives as a burst of eight beats. The tag is read at the same time as the data and is not fetched before it. The one sideband lane is split in time. The first four beats carry the stored tag word for the block, and the last four carry its ECC word.

A request gives the block the access address, and the memory then delivers beats through a beat-valid stream. The reader places each data beat into a 512-bit block register. It gathers the sideband into a tag word and an ECC word. As soon as the fourth beat lands, it compares the stored tag with the tag field of the request address. The hit/miss answer therefore comes out halfway through the data transfer, so the cache can begin a refill or forward data early. The raw ECC word is handed on unchecked for a later stage to use. A second request that arrives while a burst is still being collected is refused and flagged.

Top module: `sbc_burst_reader`

## Requirements
- R1: After reset, busy, res_valid, hit, done and req_err are all 0.
- R2: A request (req_valid high) is accepted only when busy is 0. busy reads 1 from the cycle after acceptance until the cycle after beat 7 is accepted, when it reads 0 again.
- R3: During a burst, data beat i (i = 0..7, counted in accepted beats) is stored in blk_data bits 64*i+63 down to 64*i.
- R4: The sideband of beat k (k = 0..3) is stored in tag_word bits 16*k+15 down to 16*k, so beat 0 is least significant.
- R5: The sideband of beat k (k = 4..7) is stored in ecc_word bits 16*(k-4)+15 down to 16*(k-4).
- R6: hit is 1 only when tag_word bit 63 (valid) is 1 and tag_word bits 23:0 equal req_addr bits 39:16 of the accepted request. Bits 62:24 have no effect on hit.
- R7: res_valid is high for exactly one cycle, the cycle after beat 3 is accepted. hit then holds its value until the next request is accepted, which clears it.
- R8: done is high for exactly one cycle, the cycle after beat 7 is accepted. From then on, blk_data, tag_word and ecc_word stay stable until beats of a later burst are accepted.
- R9: A cycle with beat_valid low does not advance the beat position. beat_valid while busy is 0 changes no output.
- R10: A request that arrives while busy is 1 is dropped, and the burst in progress goes on unchanged. req_err reads 1 from the following cycle until the next request is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 40 | Byte address of the requested block |
| beat_valid | input | 1 | Beat present on beat_data/beat_side |
| beat_data | input | 64 | Data part of a beat |
| beat_side | input | 16 | Sideband part of a beat |
| busy | output | 1 | A burst is being collected |
| res_valid | output | 1 | One-cycle pulse: hit is valid |
| hit | output | 1 | Stored tag is valid and matches the request tag |
| done | output | 1 | One-cycle pulse: block complete |
| blk_data | output | 512 | Assembled 64-byte data block |
| tag_word | output | 64 | Stored tag word including spare bits |
| ecc_word | output | 64 | Raw ECC word |
| req_err | output | 1 | A request was dropped during a burst |

## Verification
A beat counter that slips or skips shows up first at the tag boundary. res_valid then appears a cycle early or late, or hit is judged on a tag word with a lane missing. This is visible within one cycle of the fourth beat. A wrong lane select inside the block registers shows up as a misplaced 64-bit or 16-bit slice on blk_data, tag_word or ecc_word when done pulses. A state register that leaves the burst early or late shows up on busy and done, and on whether a stray beat or a second request disturbs the result. Beats, requests and idle gaps are therefore placed at each of these boundaries, and the outputs are read at the cycle the requirements name.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // Memory beat geometry
  localparam int unsigned BEAT_DATA_W = 64;
  localparam int unsigned SIDE_W      = 16;
  localparam int unsigned BURST_LEN   = 8;
  localparam int unsigned TAG_BEATS   = 4;
  // Address split for the direct-mapped array
  localparam int unsigned ADDR_W      = 40;
  localparam int unsigned OFFSET_W    = 6;
  localparam int unsigned INDEX_W     = 10;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } sbc_state_e;
endpackage

// File: rtl/sbc_beat_ctrl.sv
module sbc_beat_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned LEN     = sbc_pkg::BURST_LEN,
  parameter int unsigned TAG_LEN = sbc_pkg::TAG_BEATS,
  localparam int unsigned IDX_W  = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             beat_valid,
  output logic             accept,
  output logic             beat_we,
  output logic [IDX_W-1:0] beat_idx,
  output logic             tag_last,
  output logic             busy,
  output logic             done,
  output logic             req_err
);

  sbc_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic             burst_last;

  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign beat_we    = (state_q == ST_BURST) && beat_valid;
  assign beat_idx   = cnt_q;
  assign tag_last   = beat_we && (cnt_q == IDX_W'(TAG_LEN - 1));
  assign burst_last = beat_we && (cnt_q == IDX_W'(LEN - 1));

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_BURST;
          cnt_d   = '0;
          err_d   = 1'b0;
        end
      end
      ST_BURST: begin
        if (req_valid) begin
          err_d = 1'b1;
        end
        if (beat_we) begin
          if (burst_last) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + IDX_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (state_q == ST_BURST);
  assign done    = done_q;
  assign req_err = err_q;

  // R10
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> req_err);

  // R9
  idle_gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat_valid) |=> $stable(cnt_q));

  // R2
  done_leaves_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/sbc_lane_asm.sv
module sbc_lane_asm
  import sbc_pkg::*;
#(
  parameter int unsigned DW      = sbc_pkg::BEAT_DATA_W,
  parameter int unsigned SW      = sbc_pkg::SIDE_W,
  parameter int unsigned LEN     = sbc_pkg::BURST_LEN,
  parameter int unsigned TAG_LEN = sbc_pkg::TAG_BEATS,
  localparam int unsigned IDX_W  = $clog2(LEN),
  localparam int unsigned ECC_LEN = LEN - TAG_LEN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat_we,
  input  logic [IDX_W-1:0]    beat_idx,
  input  logic [DW-1:0]       beat_data,
  input  logic [SW-1:0]       beat_side,
  output logic [LEN*DW-1:0]   blk_data,
  output logic [TAG_LEN*SW-1:0] tag_word,
  output logic [TAG_LEN*SW-1:0] tag_live,
  output logic [ECC_LEN*SW-1:0] ecc_word
);

  logic [LEN-1:0][DW-1:0]     data_q;
  logic [TAG_LEN-1:0][SW-1:0] tag_q;
  logic [ECC_LEN-1:0][SW-1:0] ecc_q;

  genvar g;
  generate
    for (g = 0; g < LEN; g++) begin : g_slot
      logic slot_en;
      assign slot_en = beat_we && (beat_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q[g] <= '0;
        end else if (slot_en) begin
          data_q[g] <= beat_data;
        end
      end

      if (g < TAG_LEN) begin : g_tag
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            tag_q[g] <= '0;
          end else if (slot_en) begin
            tag_q[g] <= beat_side;
          end
        end
        // Word seen by the comparator: the lane on the wire for the last tag beat
        if (g == TAG_LEN - 1) begin : g_live_wire
          assign tag_live[g*SW +: SW] = beat_side;
        end else begin : g_live_reg
          assign tag_live[g*SW +: SW] = tag_q[g];
        end
      end else begin : g_ecc
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ecc_q[g-TAG_LEN] <= '0;
          end else if (slot_en) begin
            ecc_q[g-TAG_LEN] <= beat_side;
          end
        end
      end
    end
  endgenerate

  assign blk_data = data_q;
  assign tag_word = tag_q;
  assign ecc_word = ecc_q;

  // R8
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_we |=> ($stable(data_q) && $stable(tag_q) && $stable(ecc_q)));

endmodule

// File: rtl/sbc_tag_cmp.sv
module sbc_tag_cmp
  import sbc_pkg::*;
#(
  parameter int unsigned WORD_W = sbc_pkg::TAG_BEATS * sbc_pkg::SIDE_W,
  parameter int unsigned TAG_W  = sbc_pkg::ADDR_W - sbc_pkg::OFFSET_W - sbc_pkg::INDEX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              tag_last,
  input  logic [WORD_W-1:0] tag_live,
  output logic              res_valid,
  output logic              hit
);

  logic [TAG_W-1:0] want_q, want_d;
  logic             hit_q, hit_d;
  logic             rv_q, rv_d;
  logic             stored_ok;
  logic             tag_eq;

  assign stored_ok = tag_live[WORD_W-1];
  assign tag_eq    = (tag_live[TAG_W-1:0] == want_q);

  always_comb begin
    want_d = want_q;
    hit_d  = hit_q;
    rv_d   = tag_last;
    if (accept) begin
      want_d = req_tag;
      hit_d  = 1'b0;
    end else if (tag_last) begin
      hit_d = stored_ok && tag_eq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= '0;
      hit_q  <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      want_q <= want_d;
      hit_q  <= hit_d;
      rv_q   <= rv_d;
    end
  end

  assign res_valid = rv_q;
  assign hit       = hit_q;

  // R7
  early_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_last |=> res_valid);

  // R7
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !tag_last) |=> $stable(hit));

endmodule

// File: rtl/sbc_burst_reader.sv
module sbc_burst_reader
  import sbc_pkg::*;
#(
  parameter int unsigned DW       = sbc_pkg::BEAT_DATA_W,
  parameter int unsigned SW       = sbc_pkg::SIDE_W,
  parameter int unsigned LEN      = sbc_pkg::BURST_LEN,
  parameter int unsigned TAG_LEN  = sbc_pkg::TAG_BEATS,
  parameter int unsigned AW       = sbc_pkg::ADDR_W,
  parameter int unsigned OFF_W    = sbc_pkg::OFFSET_W,
  parameter int unsigned IDXA_W   = sbc_pkg::INDEX_W,
  localparam int unsigned TAG_LSB = OFF_W + IDXA_W,
  localparam int unsigned TAG_W   = AW - TAG_LSB,
  localparam int unsigned BIDX_W  = $clog2(LEN),
  localparam int unsigned SBW_W   = TAG_LEN * SW,
  localparam int unsigned ECCW_W  = (LEN - TAG_LEN) * SW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_addr,
  input  logic                beat_valid,
  input  logic [DW-1:0]       beat_data,
  input  logic [SW-1:0]       beat_side,
  output logic                busy,
  output logic                res_valid,
  output logic                hit,
  output logic                done,
  output logic [LEN*DW-1:0]   blk_data,
  output logic [SBW_W-1:0]    tag_word,
  output logic [ECCW_W-1:0]   ecc_word,
  output logic                req_err
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic              accept;
  logic              beat_we;
  logic [BIDX_W-1:0] beat_idx;
  logic              tag_last;
  logic [SBW_W-1:0]  tag_live;

  sbc_beat_ctrl #(
    .LEN     (LEN),
    .TAG_LEN (TAG_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .req_valid  (req_valid),
    .beat_valid (beat_valid),
    .accept     (accept),
    .beat_we    (beat_we),
    .beat_idx   (beat_idx),
    .tag_last   (tag_last),
    .busy       (busy),
    .done       (done),
    .req_err    (req_err)
  );

  sbc_lane_asm #(
    .DW      (DW),
    .SW      (SW),
    .LEN     (LEN),
    .TAG_LEN (TAG_LEN)
  ) u_asm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .beat_we   (beat_we),
    .beat_idx  (beat_idx),
    .beat_data (beat_data),
    .beat_side (beat_side),
    .blk_data  (blk_data),
    .tag_word  (tag_word),
    .tag_live  (tag_live),
    .ecc_word  (ecc_word)
  );

  sbc_tag_cmp #(
    .WORD_W (SBW_W),
    .TAG_W  (TAG_W)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .accept    (accept),
    .req_tag   (req_addr[AW-1:TAG_LSB]),
    .tag_last  (tag_last),
    .tag_live  (tag_live),
    .res_valid (res_valid),
    .hit       (hit)
  );

  // R7
  result_before_done_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(res_valid && done));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |=> !done);

endmodule

// File: tb/sbc_burst_reader_bench.sv
module sbc_burst_reader_bench;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [39:0]  req_addr;
  logic         beat_valid;
  logic [63:0]  beat_data;
  logic [15:0]  beat_side;
  logic         busy;
  logic         res_valid;
  logic         hit;
  logic         done;
  logic [511:0] blk_data;
  logic [63:0]  tag_word;
  logic [63:0]  ecc_word;
  logic         req_err;

  int checks_total;
  int checks_failed;
  logic [511:0] last_blk;

  sbc_burst_reader u_sbc_burst_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .beat_side  (beat_side),
    .busy       (busy),
    .res_valid  (res_valid),
    .hit        (hit),
    .done       (done),
    .blk_data   (blk_data),
    .tag_word   (tag_word),
    .ecc_word   (ecc_word),
    .req_err    (req_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    checks_total++;
    if (!ok) begin
      checks_failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] beat_val(input logic [31:0] seed, input int i);
    logic [31:0] s;
    s = seed + 32'(i * 32'h0101_0101);
    return {s, ~s ^ 32'(i)};
  endfunction

  // One burst. gaps: idle cycle before each beat. intrude_at: beat index at which
  // a second request is driven (-1 for none).
  task automatic run_burst(input logic [39:0] addr, input logic [63:0] tw,
                           input logic [63:0] ew, input logic [31:0] seed,
                           input bit gaps, input int intrude_at);
    logic [511:0] exp_blk;
    bit           exp_hit;
    exp_hit = tw[63] && (tw[23:0] == addr[39:16]);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~addr;
    check(busy == 1'b1, "R2 busy after accept", 512'(busy), 512'(1));
    check(req_err == 1'b0, "R10 err cleared on accept", 512'(req_err), 512'(0));
    check(hit == 1'b0, "R7 hit cleared on accept", 512'(hit), 512'(0));
    for (int i = 0; i < 8; i++) begin
      if (gaps) begin
        beat_valid = 1'b0;
        beat_data  = 64'hDEAD_BEEF_0BAD_F00D;
        beat_side  = 16'hFFFF;
        @(negedge clk);
        check(res_valid == 1'b0 && done == 1'b0, "R9 gap does not advance",
              512'({res_valid, done}), 512'(0));
      end
      beat_valid = 1'b1;
      beat_data  = beat_val(seed, i);
      beat_side  = (i < 4) ? tw[16*i +: 16] : ew[16*(i-4) +: 16];
      exp_blk[64*i +: 64] = beat_val(seed, i);
      if (i == intrude_at) begin
        req_valid = 1'b1;
        req_addr  = addr ^ 40'hFF_FFFF_0000;
      end
      @(negedge clk);
      beat_valid = 1'b0;
      req_valid  = 1'b0;
      if (i == intrude_at) begin
        check(req_err == 1'b1, "R10 err after dropped request", 512'(req_err), 512'(1));
        check(busy == 1'b1, "R10 burst continues", 512'(busy), 512'(1));
      end
      if (i == 3) begin
        check(res_valid == 1'b1, "R7 res_valid after beat 3", 512'(res_valid), 512'(1));
        check(hit == exp_hit, "R6 hit result", 512'(hit), 512'(exp_hit));
        check(tag_word == tw, "R4 tag word assembly", 512'(tag_word), 512'(tw));
      end else if (!gaps || i != 4) begin
        check(res_valid == 1'b0, "R7 res_valid single pulse", 512'(res_valid), 512'(0));
      end
      if (i == 7) begin
        check(done == 1'b1, "R8 done after beat 7", 512'(done), 512'(1));
        check(busy == 1'b0, "R2 busy low after beat 7", 512'(busy), 512'(0));
        check(blk_data == exp_blk, "R3 data placement", blk_data, exp_blk);
        check(ecc_word == ew, "R5 ECC word assembly", 512'(ecc_word), 512'(ew));
        check(hit == exp_hit, "R7 hit held", 512'(hit), 512'(exp_hit));
      end else begin
        check(done == 1'b0, "R8 done only after last beat", 512'(done), 512'(0));
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R8 done single pulse", 512'(done), 512'(0));
    check(blk_data == exp_blk, "R8 data stable after done", blk_data, exp_blk);
    last_blk = exp_blk;
  endtask

  task automatic test_reset();
    check({busy, res_valid, hit, done, req_err} == 5'b0, "R1 reset outputs",
          512'({busy, res_valid, hit, done, req_err}), 512'(0));
    check(blk_data == '0, "R1 reset data", blk_data, 512'(0));
  endtask

  task automatic test_hit();
    run_burst(40'h12_3456_7FC0, {1'b1, 39'h0, 24'h12_3456}, 64'h0123_4567_89AB_CDEF,
              32'h1111_0000, 1'b0, -1);
  endtask

  task automatic test_tag_mismatch();
    run_burst(40'h12_3456_0040, {1'b1, 39'h0, 24'h12_3457}, 64'hFEDC_BA98_7654_3210,
              32'h2222_0000, 1'b0, -1);
  endtask

  task automatic test_invalid_line();
    run_burst(40'hAB_CDEF_1200, {1'b0, 39'h0, 24'hAB_CDEF}, 64'h5555_AAAA_3333_CCCC,
              32'h3333_0000, 1'b0, -1);
  endtask

  task automatic test_spare_bits();
    // R6 spare bits 62:24 set, still a hit
    run_burst(40'h00_0001_FFFF, {1'b1, 39'h55_AAAA_AA55, 24'h00_0001}, 64'h1,
              32'h4444_0000, 1'b0, -1);
  endtask

  task automatic test_gaps();
    run_burst(40'h77_8899_0000, {1'b1, 39'h0, 24'h77_8899}, 64'h8000_0000_0000_0001,
              32'h5555_0000, 1'b1, -1);
  endtask

  task automatic test_intrude();
    run_burst(40'h44_2211_0100, {1'b1, 39'h1, 24'h44_2211}, 64'h0F0F_F0F0_0F0F_F0F0,
              32'h6666_0000, 1'b0, 2);
    check(req_err == 1'b1, "R10 err holds until next accept", 512'(req_err), 512'(1));
  endtask

  task automatic test_stray_beats();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      beat_valid = 1'b1;
      beat_data  = 64'hCAFE_0000_0000_0000 | 64'(k);
      beat_side  = 16'hA5A5;
    end
    @(negedge clk);
    beat_valid = 1'b0;
    check(blk_data == last_blk, "R9 idle beats ignored", blk_data, last_blk);
    check({res_valid, done, busy} == 3'b0, "R9 idle beats no pulses",
          512'({res_valid, done, busy}), 512'(0));
  endtask

  initial begin
    checks_total  = 0;
    checks_failed = 0;
    last_blk      = '0;
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_addr   = '0;
    beat_valid = 1'b0;
    beat_data  = '0;
    beat_side  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_hit();
    test_tag_mismatch();
    test_invalid_line();
    test_spare_bits();
    test_gaps();
    test_intrude();
    test_stray_beats();
    test_hit();
    $display("%0d/%0d checks passed", checks_total - checks_failed, checks_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks_total++;
    checks_failed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks_total - checks_failed, checks_total);
    $finish;
  end

endmodule